// File: doc/BRIEF.md
# I2C Slave Address Match and Status Unit

This block is the addressing and status side of an I2C slave. A separate shift engine handles the bus pins and reports decoded events: an address byte has arrived, a byte has finished before or after its acknowledge bit, an acknowledge has been sampled, and arbitration has been lost. The block compares each address byte with a programmed primary address. It can also accept a whole inclusive range of addresses, and it can answer the general-call address when that is enabled. It keeps the addressed state, the transfer direction and the last received acknowledge. It raises one sticky interrupt flag that software clears.

Software programs the block through a one-cycle write strobe with a small register offset. Offset 0 is control: bit 0 selects fast acknowledge and bit 1 enables range matching. Offset 1 is status, where writing 1 to bit 1 clears the interrupt flag. Offset 2 holds the primary address in bits 6:0. Offset 3 holds the lower range bound in bits 6:0. Every status output is registered, so it changes one clock edge after the event that causes it.

Top module: `i2c_slv_addr_stat`

## Requirements
- R1: After reset, addressed, dir_rd, irq_flag and rx_nack are all 0, and the control, primary and lower-bound registers are 0.
- R2: On addr_vld, the 7-bit address is addr_byte[7:1]. If it is nonzero and equals the primary address, addressed is 1 on the next cycle and irq_flag sets. An address byte that matches neither the primary address nor the range leaves addressed at 0 on the next cycle. A zero address never matches the primary address.
- R3: When control bit 1 is 1, an address byte whose nonzero 7-bit address lies between the lower bound and the primary address, both bounds included, sets addressed and irq_flag. When control bit 1 is 0, the range has no effect.
- R4: A write to offset 0 clears addressed on the next cycle, whatever the data. If addr_vld falls in the same cycle, the address compare decides the result.
- R5: On an address byte that matches the primary address, the range or the general call, dir_rd takes addr_byte[0] (0 = master writes, 1 = master reads). At all other times dir_rd holds its value.
- R6: A write to offset 1 with data bit 1 = 1 clears irq_flag. A write to offset 1 with data bit 1 = 0 leaves irq_flag unchanged. irq_flag otherwise holds its value until one of these writes clears it.
- R7: With control bit 0 = 0, byte_done_full sets irq_flag and byte_done_data does not.
- R8: With control bit 0 = 1, byte_done_data sets irq_flag and byte_done_full does not.
- R9: arb_lost sets irq_flag on the next cycle.
- R10: On ack_vld, rx_nack takes ack_nack (0 = acknowledge seen, 1 = no acknowledge). Otherwise rx_nack holds its value.
- R11: An address byte whose 7-bit address is 0 sets irq_flag and loads dir_rd only while gc_en is 1. It never sets addressed.
- R12: When a set event and a clear of irq_flag fall in the same cycle, irq_flag is 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gc_en | input | 1 | Enables the general-call address match |
| addr_vld | input | 1 | Strobe: the first byte after a START or repeated START is on addr_byte |
| addr_byte | input | 8 | Received address byte: 7-bit address in bits 7:1, R/W in bit 0 |
| byte_done_data | input | 1 | Strobe: 8 data bits done, before the acknowledge bit |
| byte_done_full | input | 1 | Strobe: byte done, including the acknowledge bit |
| ack_vld | input | 1 | Strobe: acknowledge bit sampled after a transmitted byte |
| ack_nack | input | 1 | Sampled acknowledge value, 1 = no acknowledge |
| arb_lost | input | 1 | Strobe: arbitration lost |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register offset |
| wr_data | input | 8 | Register write data |
| addressed | output | 1 | Addressed as a slave |
| dir_rd | output | 1 | Direction of the current transfer, 1 = master reads |
| irq_flag | output | 1 | Sticky interrupt flag |
| rx_nack | output | 1 | Last sampled acknowledge, 1 = no acknowledge |

## Verification
Two functions can land in the same cycle: a hardware set of the interrupt flag (arbitration loss, or an address byte together with a write) and a software action that clears state (the write-1 clear of the flag, or a control write that clears addressed). The bench drives both in one cycle: an arb_lost pulse alongside a clear of the status flag, and a matching addr_vld alongside a control write. It expects the set to win in both cases: irq_flag stays 1, and addressed is 1 on the next cycle. It also repeats the clear alone, so that a design which ignores the write entirely cannot pass.

// File: rtl/i2c_slv_pkg.sv
`timescale 1ns/1ps
package i2c_slv_pkg;

  // Register offsets decoded by the write port.
  localparam int OFS_CTRL = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_PRIM = 2;
  localparam int OFS_LOW  = 3;

  // Bit positions inside the control and status words.
  localparam int CTRL_FAST_BIT  = 0;
  localparam int CTRL_RANGE_BIT = 1;
  localparam int STAT_IRQ_BIT   = 1;

  typedef struct packed {
    logic range_en;
    logic fast_ack;
  } ctrl_t;

endpackage

// File: rtl/i2c_slv_regs.sv
`timescale 1ns/1ps
module i2c_slv_regs
  import i2c_slv_pkg::*;
#(
  parameter int RAW = 3,
  parameter int DW  = 8,
  parameter int AW  = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  output ctrl_t          ctrl,
  output logic [AW-1:0]  prim_adr,
  output logic [AW-1:0]  low_adr,
  output logic           ctrl_wr,
  output logic           irq_clr
);

  logic  sel_ctrl, sel_stat, sel_prim, sel_low;
  ctrl_t ctrl_d;
  logic [AW-1:0] prim_d, low_d;

  // Offset decode
  always_comb begin
    sel_ctrl = wr_en && (wr_addr == RAW'(OFS_CTRL));
    sel_stat = wr_en && (wr_addr == RAW'(OFS_STAT));
    sel_prim = wr_en && (wr_addr == RAW'(OFS_PRIM));
    sel_low  = wr_en && (wr_addr == RAW'(OFS_LOW));
  end

  assign ctrl_wr = sel_ctrl;
  assign irq_clr = sel_stat && wr_data[STAT_IRQ_BIT];

  // Next-state for the configuration words
  always_comb begin
    ctrl_d = ctrl;
    prim_d = prim_adr;
    low_d  = low_adr;
    if (sel_ctrl) begin
      ctrl_d.fast_ack = wr_data[CTRL_FAST_BIT];
      ctrl_d.range_en = wr_data[CTRL_RANGE_BIT];
    end
    if (sel_prim) prim_d = wr_data[AW-1:0];
    if (sel_low)  low_d  = wr_data[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      prim_adr <= '0;
      low_adr  <= '0;
    end else begin
      if (sel_ctrl) ctrl     <= ctrl_d;
      if (sel_prim) prim_adr <= prim_d;
      if (sel_low)  low_adr  <= low_d;
    end
  end

endmodule

// File: rtl/i2c_slv_match.sv
`timescale 1ns/1ps
module i2c_slv_match #(
  parameter int AW        = 7,
  parameter bit HAS_RANGE = 1'b1
) (
  input  logic [AW:0]   addr_byte,
  input  logic [AW-1:0] prim_adr,
  input  logic [AW-1:0] low_adr,
  input  logic          range_en,
  input  logic          gc_en,
  output logic          hit_own,
  output logic          hit_any,
  output logic          rw_bit
);

  logic [AW-1:0] call_adr;
  logic          nz, hit_prim, hit_rng, hit_gc;

  assign call_adr = addr_byte[AW:1];
  assign rw_bit   = addr_byte[0];
  assign nz       = |call_adr;

  assign hit_prim = nz && (call_adr == prim_adr);
  assign hit_gc   = gc_en && !nz;

  generate
    if (HAS_RANGE) begin : g_range
      assign hit_rng = range_en && nz &&
                       (call_adr >= low_adr) && (call_adr <= prim_adr);
    end else begin : g_norange
      logic unused_rng;
      assign unused_rng = range_en ^ (|low_adr);
      assign hit_rng    = 1'b0;
    end
  endgenerate

  assign hit_own = hit_prim || hit_rng;
  assign hit_any = hit_own || hit_gc;

endmodule

// File: rtl/i2c_slv_flags.sv
`timescale 1ns/1ps
module i2c_slv_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_vld,
  input  logic hit_own,
  input  logic hit_any,
  input  logic rw_bit,
  input  logic byte_done_data,
  input  logic byte_done_full,
  input  logic fast_ack,
  input  logic ack_vld,
  input  logic ack_nack,
  input  logic arb_lost,
  input  logic ctrl_wr,
  input  logic irq_clr,
  output logic addressed,
  output logic dir_rd,
  output logic irq_flag,
  output logic rx_nack
);

  logic adr_d, dir_d, irq_d, nack_d;
  logic dir_en, byte_evt, irq_set;

  assign dir_en   = addr_vld && hit_any;
  assign byte_evt = fast_ack ? byte_done_data : byte_done_full;
  assign irq_set  = dir_en || byte_evt || arb_lost;

  always_comb begin
    // Addressed: the address compare outranks a control write.
    if (addr_vld)     adr_d = hit_own;
    else if (ctrl_wr) adr_d = 1'b0;
    else              adr_d = addressed;

    dir_d = dir_en ? rw_bit : dir_rd;

    // A hardware set beats the software clear.
    if (irq_set)      irq_d = 1'b1;
    else if (irq_clr) irq_d = 1'b0;
    else              irq_d = irq_flag;

    nack_d = ack_vld ? ack_nack : rx_nack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addressed <= 1'b0;
      dir_rd    <= 1'b0;
      irq_flag  <= 1'b0;
      rx_nack   <= 1'b0;
    end else begin
      addressed <= adr_d;
      if (dir_en)  dir_rd  <= dir_d;
      irq_flag  <= irq_d;
      if (ack_vld) rx_nack <= nack_d;
    end
  end

endmodule

// File: rtl/i2c_slv_addr_stat.sv
`timescale 1ns/1ps
module i2c_slv_addr_stat
  import i2c_slv_pkg::*;
#(
  parameter int RAW       = 3,
  parameter int DW        = 8,
  parameter bit HAS_RANGE = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           gc_en,
  input  logic           addr_vld,
  input  logic [DW-1:0]  addr_byte,
  input  logic           byte_done_data,
  input  logic           byte_done_full,
  input  logic           ack_vld,
  input  logic           ack_nack,
  input  logic           arb_lost,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  output logic           addressed,
  output logic           dir_rd,
  output logic           irq_flag,
  output logic           rx_nack
);

  localparam int AW = DW - 1;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  ctrl_t         ctrl;
  logic [AW-1:0] prim_adr, low_adr;
  logic          ctrl_wr, irq_clr;
  logic          hit_own, hit_any, rw_bit;

  i2c_slv_regs #(.RAW(RAW), .DW(DW), .AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ctrl     (ctrl),
    .prim_adr (prim_adr),
    .low_adr  (low_adr),
    .ctrl_wr  (ctrl_wr),
    .irq_clr  (irq_clr)
  );

  i2c_slv_match #(.AW(AW), .HAS_RANGE(HAS_RANGE)) u_match (
    .addr_byte (addr_byte),
    .prim_adr  (prim_adr),
    .low_adr   (low_adr),
    .range_en  (ctrl.range_en),
    .gc_en     (gc_en),
    .hit_own   (hit_own),
    .hit_any   (hit_any),
    .rw_bit    (rw_bit)
  );

  i2c_slv_flags u_flags (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .addr_vld       (addr_vld),
    .hit_own        (hit_own),
    .hit_any        (hit_any),
    .rw_bit         (rw_bit),
    .byte_done_data (byte_done_data),
    .byte_done_full (byte_done_full),
    .fast_ack       (ctrl.fast_ack),
    .ack_vld        (ack_vld),
    .ack_nack       (ack_nack),
    .arb_lost       (arb_lost),
    .ctrl_wr        (ctrl_wr),
    .irq_clr        (irq_clr),
    .addressed      (addressed),
    .dir_rd         (dir_rd),
    .irq_flag       (irq_flag),
    .rx_nack        (rx_nack)
  );

endmodule

// File: rtl/i2c_slv_chk.sv
`timescale 1ns/1ps
module i2c_slv_chk
  import i2c_slv_pkg::*;
#(
  parameter int RAW = 3,
  parameter int DW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           addr_vld,
  input logic           byte_done_data,
  input logic           byte_done_full,
  input logic           ack_vld,
  input logic           ack_nack,
  input logic           arb_lost,
  input logic           wr_en,
  input logic [RAW-1:0] wr_addr,
  input logic [DW-1:0]  wr_data,
  input logic           addressed,
  input logic           dir_rd,
  input logic           irq_flag,
  input logic           rx_nack
);

  logic clr_wr, ctl_wr, any_set;
  assign clr_wr  = wr_en && (wr_addr == RAW'(OFS_STAT)) && wr_data[STAT_IRQ_BIT];
  assign ctl_wr  = wr_en && (wr_addr == RAW'(OFS_CTRL));
  assign any_set = addr_vld || arb_lost || byte_done_data || byte_done_full;

  // R9
  arb_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> irq_flag);

  // R6
  clear_wins_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !any_set) |=> !irq_flag);

  // R6
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !clr_wr) |=> irq_flag);

  // R12
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && arb_lost) |=> irq_flag);

  // R4
  ctrl_clears_adr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !addr_vld) |=> !addressed);

  // R2
  adr_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addressed) |-> $past(addr_vld));

  // R5
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> $stable(dir_rd));

  // R10
  nack_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |=> (rx_nack == $past(ack_nack)));

  // R10
  nack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_vld |=> $stable(rx_nack));

endmodule

bind i2c_slv_addr_stat i2c_slv_chk #(.RAW(RAW), .DW(DW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .addr_vld       (addr_vld),
  .byte_done_data (byte_done_data),
  .byte_done_full (byte_done_full),
  .ack_vld        (ack_vld),
  .ack_nack       (ack_nack),
  .arb_lost       (arb_lost),
  .wr_en          (wr_en),
  .wr_addr        (wr_addr),
  .wr_data        (wr_data),
  .addressed      (addressed),
  .dir_rd         (dir_rd),
  .irq_flag       (irq_flag),
  .rx_nack        (rx_nack)
);

// File: tb/sim_i2c_slv_addr_stat.sv
`timescale 1ns/1ps
module sim_i2c_slv_addr_stat;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gc_en = 1'b0;
  logic       addr_vld = 1'b0;
  logic [7:0] addr_byte = '0;
  logic       byte_done_data = 1'b0, byte_done_full = 1'b0;
  logic       ack_vld = 1'b0, ack_nack = 1'b0, arb_lost = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       addressed, dir_rd, irq_flag, rx_nack;

  always #10 clk = ~clk;

  i2c_slv_addr_stat u0 (
    .clk(clk), .rst_n(rst_n), .gc_en(gc_en),
    .addr_vld(addr_vld), .addr_byte(addr_byte),
    .byte_done_data(byte_done_data), .byte_done_full(byte_done_full),
    .ack_vld(ack_vld), .ack_nack(ack_nack), .arb_lost(arb_lost),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .addressed(addressed), .dir_rd(dir_rd), .irq_flag(irq_flag), .rx_nack(rx_nack)
  );

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench-side model state
  logic       m_adr = 0, m_dir = 0, m_irq = 0, m_nack = 0;
  logic       m_fast = 0, m_rng = 0;
  logic [6:0] m_prim = 0, m_low = 0;

  // Monitor: compares outputs 5 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if ({addressed, dir_rd, irq_flag, rx_nack} !== it.exp) begin
          errors++;
          $display("FAIL %s got %b exp %b (addressed,dir_rd,irq_flag,rx_nack)",
                   it.tag, {addressed, dir_rd, irq_flag, rx_nack}, it.exp);
        end
      end
    end
  end

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic step(input string tag, input logic av, input logic [7:0] ab,
                      input logic bdd, input logic bdf, input logic akv,
                      input logic akn, input logic al, input logic we,
                      input logic [2:0] wa, input logic [7:0] wd);
    logic [6:0] a7;
    logic hp, hr, hg, own, any, set, clr;
    item_t it;
    @(negedge clk);
    addr_vld = av; addr_byte = ab; byte_done_data = bdd; byte_done_full = bdf;
    ack_vld = akv; ack_nack = akn; arb_lost = al;
    wr_en = we; wr_addr = wa; wr_data = wd;
    a7  = ab[7:1];
    hp  = (a7 != 0) && (a7 == m_prim);
    hr  = m_rng && (a7 != 0) && (a7 >= m_low) && (a7 <= m_prim);
    hg  = gc_en && (a7 == 0);
    own = hp || hr;
    any = own || hg;
    set = (av && any) || al || (m_fast ? bdd : bdf);
    clr = we && (wa == 3'd1) && wd[1];
    if (av) m_adr = own;
    else if (we && wa == 3'd0) m_adr = 0;
    if (av && any) m_dir = ab[0];
    if (set) m_irq = 1;
    else if (clr) m_irq = 0;
    if (akv) m_nack = akn;
    if (we && wa == 3'd0) begin m_fast = wd[0]; m_rng = wd[1]; end
    if (we && wa == 3'd2) m_prim = wd[6:0];
    if (we && wa == 3'd3) m_low = wd[6:0];
    it.exp = {m_adr, m_dir, m_irq, m_nack};
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 8'h00, 0, 0, 0, 0, 0, 0, 3'd0, 8'h00);
  endtask
  task automatic wr(input string tag, input logic [2:0] a, input logic [7:0] d);
    step(tag, 0, 8'h00, 0, 0, 0, 0, 0, 1, a, d);
  endtask
  task automatic adr(input string tag, input logic [6:0] a, input logic rw);
    step(tag, 1, {a, rw}, 0, 0, 0, 0, 0, 0, 3'd0, 8'h00);
  endtask
  task automatic clr_irq(input string tag);
    wr(tag, 3'd1, 8'h02);
  endtask

  initial begin
    #15;
    checks++;
    if ({addressed, dir_rd, irq_flag, rx_nack} !== 4'b0000) begin
      errors++;
      $display("FAIL R1 got %b exp 0000", {addressed, dir_rd, irq_flag, rx_nack});
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    idle("R1 idle after reset");

    // R2 primary match
    wr("R2 set primary", 3'd2, 8'h3A);
    adr("R2 primary hit write", 7'h3A, 0);
    clr_irq("R6 clear irq");
    step("R9 arb lost", 0, 8'h00, 0, 0, 0, 0, 1, 0, 3'd0, 8'h00);
    wr("R6 write 0 to flag bit", 3'd1, 8'hFD);
    clr_irq("R6 clear irq again");
    idle("R6 stays clear");
    wr("R4 ctrl write clears addressed", 3'd0, 8'h00);
    adr("R5 primary hit read", 7'h3A, 1);
    clr_irq("R6 clear");
    adr("R2 miss clears addressed", 7'h10, 0);
    idle("R5 dir holds");

    // R3 range
    wr("R3 set low", 3'd3, 8'h30);
    wr("R3 range on", 3'd0, 8'h02);
    adr("R3 lower bound", 7'h30, 0);
    clr_irq("R6 clear");
    adr("R3 below range", 7'h2F, 1);
    adr("R3 mid range", 7'h35, 1);
    clr_irq("R6 clear");
    adr("R3 above primary", 7'h3B, 0);
    wr("R3 range off", 3'd0, 8'h00);
    adr("R3 mid with range off", 7'h35, 0);

    // R11 general call, zero primary
    wr("R2 primary zero", 3'd2, 8'h00);
    adr("R2 zero addr no gc", 7'h00, 1);
    idle("R11 nothing set");
    gc_en = 1'b1;
    adr("R11 general call", 7'h00, 1);
    clr_irq("R6 clear");
    gc_en = 1'b0;

    // R7 / R8 byte completion
    step("R7 data-done ignored", 0, 8'h00, 1, 0, 0, 0, 0, 0, 3'd0, 8'h00);
    step("R7 full-done sets", 0, 8'h00, 0, 1, 0, 0, 0, 0, 3'd0, 8'h00);
    clr_irq("R6 clear");
    wr("R8 fast ack on", 3'd0, 8'h01);
    step("R8 full-done ignored", 0, 8'h00, 0, 1, 0, 0, 0, 0, 3'd0, 8'h00);
    step("R8 data-done sets", 0, 8'h00, 1, 0, 0, 0, 0, 0, 3'd0, 8'h00);
    clr_irq("R6 clear");

    // R10 acknowledge capture
    step("R10 nack", 0, 8'h00, 0, 0, 1, 1, 0, 0, 3'd0, 8'h00);
    step("R10 holds", 0, 8'h00, 0, 0, 0, 0, 0, 0, 3'd0, 8'h00);
    step("R10 ack", 0, 8'h00, 0, 0, 1, 0, 0, 0, 3'd0, 8'h00);

    // R12 set and clear together, irq initially 0
    step("R12 set beats clear", 0, 8'h00, 0, 0, 0, 0, 1, 1, 3'd1, 8'h02);
    step("R12 set beats clear held", 0, 8'h00, 0, 0, 0, 0, 1, 1, 3'd1, 8'h02);
    clr_irq("R6 clear");

    // R4 address match together with control write
    wr("R4 primary", 3'd2, 8'h21);
    step("R4 match wins over ctrl write", 1, {7'h21, 1'b0}, 0, 0, 0, 0, 0, 1, 3'd0, 8'h00);
    wr("R4 ctrl write any data", 3'd0, 8'hFC);
    idle("R4 final");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired got running exp finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule